// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block takes eight interrupt request lines and drives one interrupt line to a CPU. It records every request it sees, drops any line whose mask bit is set, and picks the most urgent remaining request. When the CPU acknowledges, the chosen level moves from pending to in service and the block hands back a vector address for that level. The vector is a programmed base plus the level times a spacing of 4 or 8 bytes.

Priority is not fixed. Software sets it by naming the bottom level, and the level just above the bottom becomes the top. The order can also rotate by itself when an end-of-interrupt command arrives, or through a specific end-of-interrupt command that names the level it retires. A special mask mode lets lower levels interrupt while a masked higher level is still in service.

A small register bus carries all configuration and commands. Reads of the status register return either the pending or the in-service set, chosen by a command. Acknowledge and vector form a single-cycle exchange. A one-cycle pulse on `inta` produces `vec_valid` for one cycle on the following clock. There is no back-pressure: the vector must be taken in the cycle it is valid.

Top module: `rpic_top`

## Requirements
- R1: After reset the pending, in-service and mask sets are all zero, and `irq` is low. The bottom level is 7, automatic rotation and special mask mode are off, status reads return the pending set, and the configuration byte is 0.
- R2: With the bottom level at 7, a lower index has higher priority. When levels 4 and 6 request together, level 4 is acknowledged first. The vector is the aligned base plus level×spacing.
- R3: A one-cycle `inta` while `irq` is high has several effects. It clears the chosen level's pending bit and sets its in-service bit. On the next clock it drives `vec_valid` high for one cycle with the vector on `vec`.
- R4: A level in service blocks `irq` for pending levels of equal or lower priority. A pending level of higher priority still raises `irq`, so interrupts can nest.
- R5: Command opcode 1 is the non-specific end-of-interrupt. It clears the highest-priority bit that is set in the in-service set.
- R6: Opcode 4 sets automatic rotation, with the flag in bit 0. While it is on, a non-specific end-of-interrupt also makes the retired level the bottom priority.
- R7: Opcode 3 is the specific rotating end-of-interrupt. It clears the in-service bit of the level held in bits 2:0 and makes that level the bottom priority.
- R8: Opcode 2 makes the level held in bits 2:0 the bottom priority. The in-service set stays unchanged.
- R9: A masked line never raises `irq`, but its request is still recorded in the pending set. The mask is written at address 0.
- R10: While special mask mode is off, a level that is masked while in service goes on blocking lower levels until an end-of-interrupt clears it.
- R11: Opcode 5 sets special mask mode, with the flag in bit 0. While it is on, masked in-service levels do not block, and unmasked in-service levels still block as in R4.
- R12: Opcode 6 with bit 0 set makes address 1 read the in-service set; with bit 0 clear it reads the pending set. Commands are written at address 1 with the opcode in bits 7:5.
- R13: The configuration byte is written at address 2 and read back unchanged. Bit 0 selects 8-byte spacing when it is 1 and 4-byte spacing when it is 0. The base is the byte with its low 5 bits cleared for 4-byte spacing and its low 6 bits cleared for 8-byte spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir | input | 8 | Request lines; a high level sets the pending bit |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| irq | output | 1 | Interrupt request to the CPU |
| inta | input | 1 | Acknowledge pulse from the CPU |
| vec_valid | output | 1 | Vector valid, one cycle after the acknowledge |
| vec | output | 8 | Vector address of the acknowledged level |

## Verification
Each result has a fixed delay after its stimulus:
- A request pulse reaches the pending set at the next rising edge, and `irq` follows combinationally in that same cycle.
- A register write or command takes effect at the edge that samples it, and `rdata` is combinational.
- The vector appears one edge after the acknowledge is sampled.

The tasks drive inputs on falling edges. They check `irq` and `rdata` at the next falling edge, and check the vector one time unit after the rising edge that sampled `inta`.

// File: rtl/rpic_pkg.sv
package rpic_pkg;
  localparam logic [1:0] A_MASK = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_CFG  = 2'd2;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_EOI    = 3'd1,
    OP_SETBOT = 3'd2,
    OP_SEOI   = 3'd3,
    OP_AUTO   = 3'd4,
    OP_SMM    = 3'd5,
    OP_RDSEL  = 3'd6
  } cmd_op_e;
endpackage

// File: rtl/rpic_prio_find.sv
// Finds the first set bit of req, scanning upward from level `top` with wrap.
module rpic_prio_find #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [LW-1:0] top,
  output logic          found,
  output logic [LW-1:0] lvl,
  output logic [LW-1:0] rank
);
  always_comb begin
    found = 1'b0;
    lvl   = '0;
    rank  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      logic [LW-1:0] idx;
      idx = top + LW'(k);
      if (req[idx]) begin
        found = 1'b1;
        lvl   = idx;
        rank  = LW'(k);
      end
    end
  end
endmodule

// File: rtl/rpic_vector.sv
module rpic_vector #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [DW-1:0] cfg,
  input  logic [LW-1:0] lvl,
  output logic [DW-1:0] vec
);
  localparam int SH4 = $clog2(4 * N);
  localparam int SH8 = $clog2(8 * N);

  logic [DW-1:0] base_al, offs;

  always_comb begin
    if (cfg[0]) begin
      base_al = (cfg >> SH8) << SH8;
      offs    = DW'(lvl) << 3;
    end else begin
      base_al = (cfg >> SH4) << SH4;
      offs    = DW'(lvl) << 2;
    end
    vec = base_al + offs;
  end
endmodule

// File: rtl/rpic_top.sv
module rpic_top #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  ir,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  input  logic          inta,
  output logic          vec_valid,
  output logic [DW-1:0] vec
);
  import rpic_pkg::*;

  logic [N-1:0]  irr_q, isr_q, mask_q;
  logic [LW-1:0] bot_q;
  logic          auto_q, smm_q, rdsel_q;
  logic [DW-1:0] cfg_q;

  logic [LW-1:0] top;
  logic [N-1:0]  pend, blk;
  logic          p_found, b_found, r_found;
  logic [LW-1:0] p_lvl, b_lvl, r_lvl, p_rank, b_rank, r_rank;
  logic [DW-1:0] vec_c;

  assign top  = bot_q + LW'(1);
  assign pend = irr_q & ~mask_q;
  assign blk  = smm_q ? (isr_q & ~mask_q) : isr_q;

  rpic_prio_find #(.N(N), .LW(LW)) u_pend (
    .req(pend), .top(top), .found(p_found), .lvl(p_lvl), .rank(p_rank));
  rpic_prio_find #(.N(N), .LW(LW)) u_blk (
    .req(blk), .top(top), .found(b_found), .lvl(b_lvl), .rank(b_rank));
  rpic_prio_find #(.N(N), .LW(LW)) u_raw (
    .req(isr_q), .top(top), .found(r_found), .lvl(r_lvl), .rank(r_rank));

  rpic_vector #(.N(N), .DW(DW), .LW(LW)) u_vec (
    .cfg(cfg_q), .lvl(p_lvl), .vec(vec_c));

  assign irq = p_found && (!b_found || (p_rank < b_rank));

  // Command decode
  cmd_op_e       op;
  logic          is_cmd, ack_ok;
  logic [LW-1:0] cmd_lvl;
  logic [N-1:0]  isr_clr, isr_set, irr_clr;

  assign is_cmd  = wr_en && (addr == A_CMD);
  assign op      = cmd_op_e'(wdata[7:5]);
  assign cmd_lvl = wdata[LW-1:0];
  assign ack_ok  = inta && irq;

  always_comb begin
    isr_clr = '0;
    isr_set = '0;
    irr_clr = '0;
    if (is_cmd && op == OP_EOI && r_found) isr_clr[r_lvl] = 1'b1;
    if (is_cmd && op == OP_SEOI)           isr_clr[cmd_lvl] = 1'b1;
    if (ack_ok) begin
      isr_set[p_lvl] = 1'b1;
      irr_clr[p_lvl] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q     <= '0;
      isr_q     <= '0;
      mask_q    <= '0;
      bot_q     <= LW'(N - 1);
      auto_q    <= 1'b0;
      smm_q     <= 1'b0;
      rdsel_q   <= 1'b0;
      cfg_q     <= '0;
      vec_valid <= 1'b0;
      vec       <= '0;
    end else begin
      irr_q     <= (irr_q & ~irr_clr) | ir;
      isr_q     <= (isr_q & ~isr_clr) | isr_set;
      vec_valid <= ack_ok;
      if (ack_ok) vec <= vec_c;
      if (wr_en && addr == A_MASK) mask_q <= wdata[N-1:0];
      if (wr_en && addr == A_CFG)  cfg_q  <= wdata;
      if (is_cmd) begin
        case (op)
          OP_EOI:    if (auto_q && r_found) bot_q <= r_lvl;
          OP_SETBOT: bot_q   <= cmd_lvl;
          OP_SEOI:   bot_q   <= cmd_lvl;
          OP_AUTO:   auto_q  <= wdata[0];
          OP_SMM:    smm_q   <= wdata[0];
          OP_RDSEL:  rdsel_q <= wdata[0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_MASK:  rdata = DW'(mask_q);
      A_CMD:   rdata = rdsel_q ? DW'(isr_q) : DW'(irr_q);
      A_CFG:   rdata = cfg_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/rpic_chk.sv
module rpic_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         inta,
  input logic         irq,
  input logic         vec_valid,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [7:0]   wdata,
  input logic [N-1:0] irr_q,
  input logic [N-1:0] isr_q,
  input logic [N-1:0] mask_q
);
  p_irq_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((irr_q & ~mask_q) != '0));

  p_vec_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && irq) |=> vec_valid);

  p_vec_needs_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(inta && irq));

  p_ack_sets_isr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && irq) |=> (isr_q != '0));

  p_setbot_keeps_isr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && wdata[7:5] == 3'd2 && !inta) |=> $stable(isr_q));

  p_seoi_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && wdata[7:5] == 3'd3 && !inta)
      |=> (isr_q[$past(wdata[2:0])] == 1'b0));
endmodule

bind rpic_top rpic_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .inta(inta), .irq(irq), .vec_valid(vec_valid),
  .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irr_q(irr_q), .isr_q(isr_q), .mask_q(mask_q));

// File: tb/sim_rpic_top.sv
module sim_rpic_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ir = '0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  logic       inta = 1'b0;
  logic       vec_valid;
  logic [7:0] vec;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rpic_top u0 (
    .clk(clk), .rst_n(rst_n), .ir(ir), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .inta(inta),
    .vec_valid(vec_valid), .vec(vec));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] op, input logic [2:0] lvl);
    wr(2'd1, {op, 2'b00, lvl});
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk);
    ir = v;
    @(negedge clk);
    ir = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic rd_isr(input logic [7:0] exp, input string req);
    cmd(3'd6, 3'd1);
    rd(2'd1, exp, req);
  endtask

  task automatic rd_irr(input logic [7:0] exp, input string req);
    cmd(3'd6, 3'd0);
    rd(2'd1, exp, req);
  endtask

  task automatic ack(input logic [7:0] exp_vec, input string req);
    @(negedge clk);
    chk({req, " irq before ack"}, irq, 1);
    inta = 1'b1;
    @(posedge clk);
    #1;
    chk({req, " vec_valid"}, vec_valid, 1);
    chk({req, " vector"}, vec, exp_vec);
    @(negedge clk);
    inta = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 irq", irq, 0);
    rd(2'd0, 8'h00, "R1 mask");
    rd(2'd1, 8'h00, "R1 pending");
    rd(2'd2, 8'h00, "R1 cfg");
    rd_isr(8'h00, "R1 isr");
  endtask

  task automatic t_fixed;
    pulse(8'h50);
    ack(8'd16, "R2 IR4 first");
    rd_isr(8'h10, "R3 isr set");
    rd_irr(8'h40, "R3 pending cleared");
    chk("R4 lower blocked", irq, 0);
    pulse(8'h04);
    chk("R4 nesting higher", irq, 1);
    ack(8'd8, "R4 IR2 nested");
    cmd(3'd1, 3'd0);
    rd_isr(8'h10, "R5 eoi clears highest");
    cmd(3'd1, 3'd0);
    rd_isr(8'h00, "R5 second eoi");
    ack(8'd24, "R2 IR6 after");
    cmd(3'd1, 3'd0);
  endtask

  task automatic t_auto;
    cmd(3'd4, 3'd1);
    pulse(8'h50);
    ack(8'd16, "R6 IR4 first");
    cmd(3'd1, 3'd0);
    pulse(8'h10);
    ack(8'd24, "R6 IR6 after rotation");
    cmd(3'd1, 3'd0);
    ack(8'd16, "R6 IR4 last");
    cmd(3'd1, 3'd0);
    cmd(3'd4, 3'd0);
    cmd(3'd2, 3'd7);
  endtask

  task automatic t_specific;
    pulse(8'h0A);
    ack(8'd4, "R7 IR1 first");
    cmd(3'd3, 3'd1);
    rd_isr(8'h00, "R7 seoi clears level");
    ack(8'd12, "R7 IR3 next");
    cmd(3'd3, 3'd3);
    rd_isr(8'h00, "R7 seoi clears IR3");
    cmd(3'd2, 3'd7);
  endtask

  task automatic t_setbot;
    pulse(8'h04);
    ack(8'd8, "R8 IR2");
    cmd(3'd2, 3'd5);
    rd_isr(8'h04, "R8 isr unchanged");
    pulse(8'h41);
    ack(8'd24, "R8 IR6 now top");
    chk("R4 IR0 blocked by IR6", irq, 0);
    cmd(3'd1, 3'd0);
    rd_isr(8'h04, "R5 eoi clears IR6 under rotation");
    ack(8'd0, "R8 IR0 beats IR2");
    cmd(3'd1, 3'd0);
    cmd(3'd1, 3'd0);
    rd_isr(8'h00, "R5 all cleared");
    cmd(3'd2, 3'd7);
  endtask

  task automatic t_mask;
    wr(2'd0, 8'h08);
    pulse(8'h08);
    chk("R9 masked no irq", irq, 0);
    rd_irr(8'h08, "R9 pending recorded");
    rd(2'd0, 8'h08, "R9 mask readback");
    wr(2'd0, 8'h00);
    ack(8'd12, "R9 unmasked IR3");
    cmd(3'd1, 3'd0);
  endtask

  task automatic t_smm;
    pulse(8'h04);
    ack(8'd8, "R10 IR2");
    wr(2'd0, 8'h04);
    pulse(8'h20);
    chk("R10 masked isr blocks", irq, 0);
    cmd(3'd5, 3'd1);
    chk("R11 smm lets lower in", irq, 1);
    ack(8'd20, "R11 IR5");
    cmd(3'd1, 3'd0);
    rd_isr(8'h20, "R10 eoi clears IR2");
    cmd(3'd1, 3'd0);
    cmd(3'd5, 3'd0);
    wr(2'd0, 8'h00);
    rd_isr(8'h00, "R11 cleanup");
  endtask

  task automatic t_vec;
    wr(2'd2, 8'hC1);
    rd(2'd2, 8'hC1, "R13 cfg readback");
    pulse(8'h80);
    ack(8'hF8, "R13 spacing 8");
    cmd(3'd1, 3'd0);
    wr(2'd2, 8'hB0);
    pulse(8'h08);
    ack(8'hAC, "R13 spacing 4 aligned");
    cmd(3'd1, 3'd0);
    rd_irr(8'h00, "R12 pending read");
    rd_isr(8'h00, "R12 isr read");
    wr(2'd2, 8'h00);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_auto();
    t_specific();
    t_setbot();
    t_mask();
    t_smm();
    t_vec();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule